// File: doc/BRIEF.md
# State-Gated Coulomb Counter with Bounded Re-Anchoring

This block keeps a battery state-of-charge figure by integrating signed current samples. On each sample strobe, the offset-corrected current is multiplied by a gain input and added to a fixed-point accumulator. The gain input is the reciprocal of rated capacity, expressed as the fraction of one 0.01 % SoC step that a single milliamp sample is worth. The accumulator keeps fractional bits below the output resolution, so small currents are not lost to truncation. The SoC result is clamped to the range 0 to 100.00 %.

A two-bit power-state input selects how samples are used:

- In the active states, samples are integrated.
- In the frozen states, integration stops. Each strobe then refines a zero-current offset estimate instead. That estimate is subtracted from every later active sample.

When the gauge leaves a frozen state, the block re-anchors SoC toward an externally supplied SoC value derived from rest voltage. It does not load that value in one go. Instead it moves toward it in bounded steps, at most one step per configured tick interval. Each applied step raises a one-cycle event. The event carries a reason code and a free-running timestamp.

Top module: `soc_integrator`

## Requirements
- R1: While reset is held and on the first cycle after it, `soc` is 0 and `corr_evt` and `corr_rsn` are 0.
- R2: In state 0 (run) or 3 (wake), each cycle with `smp_vld` high adds (sample − offset) × `gain` to an accumulator holding FRAC_W fraction bits. `soc` is the integer part of that accumulator (0.01 % units), and it is visible on the cycle after the sampled edge.
- R3: With `chg_pos` = 1 a positive sample is charge and raises SoC. With `chg_pos` = 0 a positive sample is discharge and lowers it.
- R4: The sub-LSB residue is retained between samples. With `gain` = 64 and FRAC_W = 8, four samples of +1 raise `soc` by exactly one.
- R5: `soc` saturates at 0 and at 10000 (100.00 %). It never goes below 0 or above 10000.
- R6: In state 1 (hold) or 2 (ship), sample strobes leave `soc` unchanged.
- R7: A change from state 1 or 2 to state 0 or 3 starts a re-anchoring. Its first step lands TICK_CYCLES clock edges after the edge that saw the change. Later steps follow exactly every TICK_CYCLES edges.
- R8: Each step moves `soc` toward `ocv_soc` by min(|ocv_soc − soc|, STEP_MAX). Once `soc` equals `ocv_soc` the re-anchoring ends, with no further event. An exit with `soc` already equal to `ocv_soc` produces no event.
- R9: Each applied step raises `corr_evt` for exactly one cycle. On that cycle `corr_rsn` is 1 if the exit was from ship and 2 if it was from hold. Consecutive events of one re-anchoring carry `corr_ts` values exactly TICK_CYCLES apart.
- R10: Strobes in state 1 or 2 update the offset as off ← off + ((sample − off) >>> OFF_SH), starting from 0 at reset. Active samples subtract this offset before scaling.
- R11: Entering state 1 or 2 aborts a re-anchoring in progress. No event then occurs, and `soc` stays unchanged while frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Current sample strobe |
| smp_ma | input | CUR_W | Signed two's-complement current sample, mA |
| chg_pos | input | 1 | 1: positive sample means charge; 0: positive means discharge |
| gain | input | GAIN_W | Reciprocal rated capacity: accumulator units per mA sample |
| pstate | input | 2 | Power state: 0 run, 1 hold, 2 ship, 3 wake |
| ocv_soc | input | SOC_W | Rest-voltage SoC target, 0.01 % units |
| soc | output | SOC_W | State of charge, 0.01 % units |
| corr_evt | output | 1 | One-cycle pulse per applied correction step |
| corr_rsn | output | 2 | Reason code with the event: 1 wake from ship, 2 exit from hold |
| corr_ts | output | TS_W | Free-running timestamp captured at the step |

## Verification
The assertions assume the following about the inputs and parameters:

- `pstate` and `ocv_soc` change only between clock edges.
- `ocv_soc` never exceeds 10000.
- TICK_CYCLES is at least 2, so two events can never be adjacent.

The step-size property is checked only on steps that do not coincide with an integrated sample, because a coincident sample legitimately adds its own delta. The stimulus respects these limits. It drives only legal targets and keeps `smp_vld` low throughout every re-anchoring window. It also holds state and target steady between the chosen edges, so every expected value follows from plain arithmetic on the sample, gain and offset.

// File: rtl/cc_gauge_pkg.sv
package cc_gauge_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HOLD = 2'd1,
    PS_SHIP = 2'd2,
    PS_WAKE = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_WAKE = 2'd1,
    RSN_PATH = 2'd2
  } rsn_e;

  // Integration is suspended in the resting states.
  function automatic logic is_frozen(input logic [1:0] st);
    return (st == PS_HOLD) || (st == PS_SHIP);
  endfunction

endpackage

// File: rtl/cc_offset_trim.sv
// Zero-current offset estimator; learns only while the gauge rests.
module cc_offset_trim #(
  parameter int CUR_W  = 16,
  parameter int OFF_SH = 4,
  localparam int ADJ_W = CUR_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    learn_en,
  input  logic signed [CUR_W-1:0] smp,
  output logic signed [ADJ_W-1:0] cur_adj
);

  logic signed [ADJ_W-1:0] off_q;
  logic signed [ADJ_W-1:0] smp_x;

  assign smp_x   = ADJ_W'(smp);
  assign cur_adj = smp_x - off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else if (learn_en) begin
      off_q <= off_q + (cur_adj >>> OFF_SH);
    end
  end

endmodule

// File: rtl/cc_accum.sv
// Fixed-point charge accumulator with fractional residue and clamping.
module cc_accum #(
  parameter int CUR_W    = 16,
  parameter int GAIN_W   = 16,
  parameter int FRAC_W   = 16,
  parameter int SOC_W    = 14,
  parameter int SOC_FULL = 10000,
  localparam int ADJ_W   = CUR_W + 2,
  localparam int STEP_W  = SOC_W + 2,
  localparam int ACC_W   = SOC_W + FRAC_W,
  localparam int PROD_W  = ADJ_W + GAIN_W + 1,
  localparam int SUM_W   = ((PROD_W > ACC_W + 1) ? PROD_W : ACC_W + 1) + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     int_en,
  input  logic signed [ADJ_W-1:0]  cur_adj,
  input  logic                     chg_pos,
  input  logic [GAIN_W-1:0]        gain,
  input  logic                     step_en,
  input  logic signed [STEP_W-1:0] step,
  output logic [SOC_W-1:0]         soc
);

  localparam logic signed [SUM_W-1:0] FULL_X = SUM_W'(SOC_FULL) <<< FRAC_W;
  localparam logic [ACC_W-1:0]        FULL_A = ACC_W'(SOC_FULL) << FRAC_W;

  logic [ACC_W-1:0]         acc_q;
  logic [ACC_W-1:0]         acc_d;
  logic signed [ADJ_W-1:0]  pol;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  acc_x;
  logic signed [SUM_W-1:0]  prod_x;
  logic signed [SUM_W-1:0]  step_x;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    pol    = chg_pos ? cur_adj : -cur_adj;
    prod   = PROD_W'(pol) * PROD_W'($signed({1'b0, gain}));
    acc_x  = SUM_W'($signed({1'b0, acc_q}));
    prod_x = int_en  ? SUM_W'(prod) : '0;
    step_x = step_en ? (SUM_W'(step) <<< FRAC_W) : '0;
    sum    = acc_x + prod_x + step_x;
    if (sum < 0) begin
      acc_d = '0;
    end else if (sum > FULL_X) begin
      acc_d = FULL_A;
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign soc = acc_q[ACC_W-1:FRAC_W];

endmodule

// File: rtl/cc_corr_ctrl.sv
// Exit detection, tick pacing and bounded step generation for re-anchoring.
module cc_corr_ctrl #(
  parameter int SOC_W       = 14,
  parameter int STEP_MAX    = 300,
  parameter int TICK_CYCLES = 8,
  parameter int TS_W        = 32,
  localparam int STEP_W     = SOC_W + 2,
  localparam int CNT_W      = $clog2(TICK_CYCLES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               pstate,
  input  logic [SOC_W-1:0]         soc,
  input  logic [SOC_W-1:0]         ocv_soc,
  output logic                     step_en,
  output logic signed [STEP_W-1:0] step,
  output logic                     evt,
  output logic [1:0]               rsn,
  output logic [TS_W-1:0]          ts
);
  import cc_gauge_pkg::*;

  localparam logic signed [STEP_W-1:0] STEP_P = STEP_W'(STEP_MAX);
  localparam logic signed [STEP_W-1:0] STEP_N = -STEP_P;
  localparam logic [CNT_W-1:0]         CNT_LAST = CNT_W'(TICK_CYCLES - 1);

  logic [1:0]               prev_q;
  logic                     active_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [1:0]               rsn_lat_q;
  logic [TS_W-1:0]          ts_cnt_q;
  logic                     frozen_now;
  logic                     exit_rest;
  logic                     tick;
  logic                     done;
  logic signed [STEP_W-1:0] diff;

  always_comb begin
    frozen_now = is_frozen(pstate);
    exit_rest  = is_frozen(prev_q) && !frozen_now;
    diff       = $signed({2'b00, ocv_soc}) - $signed({2'b00, soc});
    if (diff > STEP_P) begin
      step = STEP_P;
    end else if (diff < STEP_N) begin
      step = STEP_N;
    end else begin
      step = diff;
    end
    tick    = active_q && (cnt_q == CNT_LAST) && !frozen_now;
    step_en = tick && (diff != '0);
    done    = tick && (step == diff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= PS_RUN;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      rsn_lat_q <= RSN_NONE;
      ts_cnt_q  <= '0;
      evt       <= 1'b0;
      rsn       <= RSN_NONE;
      ts        <= '0;
    end else begin
      prev_q   <= pstate;
      ts_cnt_q <= ts_cnt_q + 1'b1;
      evt      <= step_en;
      rsn      <= step_en ? rsn_lat_q : RSN_NONE;
      if (step_en) begin
        ts <= ts_cnt_q;
      end
      if (frozen_now) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (exit_rest) begin
        active_q  <= 1'b1;
        cnt_q     <= '0;
        rsn_lat_q <= (prev_q == PS_SHIP) ? RSN_WAKE : RSN_PATH;
      end else if (active_q) begin
        if (tick) begin
          cnt_q <= '0;
          if (done) begin
            active_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/soc_integrator.sv
// State-gated coulomb counter with bounded post-rest re-anchoring.
module soc_integrator #(
  parameter int CUR_W       = 16,
  parameter int GAIN_W      = 16,
  parameter int FRAC_W      = 16,
  parameter int STEP_MAX    = 300,
  parameter int TICK_CYCLES = 375_000_000,
  parameter int OFF_SH      = 4,
  parameter int TS_W        = 32,
  localparam int SOC_FULL   = 10000,
  localparam int SOC_W      = $clog2(SOC_FULL + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [CUR_W-1:0] smp_ma,
  input  logic                    chg_pos,
  input  logic [GAIN_W-1:0]       gain,
  input  logic [1:0]              pstate,
  input  logic [SOC_W-1:0]        ocv_soc,
  output logic [SOC_W-1:0]        soc,
  output logic                    corr_evt,
  output logic [1:0]              corr_rsn,
  output logic [TS_W-1:0]         corr_ts
);
  import cc_gauge_pkg::*;

  localparam int ADJ_W  = CUR_W + 2;
  localparam int STEP_W = SOC_W + 2;

  logic                     frozen;
  logic                     int_en;
  logic                     learn_en;
  logic signed [ADJ_W-1:0]  cur_adj;
  logic                     step_en;
  logic signed [STEP_W-1:0] step;

  assign frozen   = is_frozen(pstate);
  assign int_en   = smp_vld && !frozen;
  assign learn_en = smp_vld && frozen;

  cc_offset_trim #(
    .CUR_W (CUR_W),
    .OFF_SH(OFF_SH)
  ) u_trim (
    .clk     (clk),
    .rst     (rst),
    .learn_en(learn_en),
    .smp     (smp_ma),
    .cur_adj (cur_adj)
  );

  cc_accum #(
    .CUR_W   (CUR_W),
    .GAIN_W  (GAIN_W),
    .FRAC_W  (FRAC_W),
    .SOC_W   (SOC_W),
    .SOC_FULL(SOC_FULL)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .int_en (int_en),
    .cur_adj(cur_adj),
    .chg_pos(chg_pos),
    .gain   (gain),
    .step_en(step_en),
    .step   (step),
    .soc    (soc)
  );

  cc_corr_ctrl #(
    .SOC_W      (SOC_W),
    .STEP_MAX   (STEP_MAX),
    .TICK_CYCLES(TICK_CYCLES),
    .TS_W       (TS_W)
  ) u_corr (
    .clk    (clk),
    .rst    (rst),
    .pstate (pstate),
    .soc    (soc),
    .ocv_soc(ocv_soc),
    .step_en(step_en),
    .step   (step),
    .evt    (corr_evt),
    .rsn    (corr_rsn),
    .ts     (corr_ts)
  );

endmodule

// File: rtl/soc_integrator_chk.sv
module soc_integrator_chk #(
  parameter int SOC_W       = 14,
  parameter int STEP_MAX    = 300,
  parameter int TICK_CYCLES = 8,
  localparam int SOC_FULL   = 10000,
  localparam int GAP_W      = $clog2(TICK_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic [1:0]       pstate,
  input logic [SOC_W-1:0] soc,
  input logic             corr_evt,
  input logic [1:0]       corr_rsn
);

  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(TICK_CYCLES);

  logic             frozen;
  logic [GAP_W-1:0] gap_q;

  assign frozen = (pstate == 2'd1) || (pstate == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_FULL;
    end else if (corr_evt) begin
      gap_q <= GAP_W'(1);
    end else if (gap_q < GAP_FULL) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_SOC_CEILING: assert property (@(posedge clk) disable iff (rst)
    soc <= SOC_W'(SOC_FULL)); // R5

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(frozen) |-> $stable(soc)); // R6

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    corr_evt |-> gap_q >= GAP_FULL); // R7

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (corr_evt && !$past(smp_vld)) |->
      (((soc >= $past(soc)) ? (soc - $past(soc)) : ($past(soc) - soc)) <= SOC_W'(STEP_MAX))); // R8

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    corr_evt |=> !corr_evt); // R9

  AST_EVT_TAGGED: assert property (@(posedge clk) disable iff (rst)
    corr_evt |-> (corr_rsn == 2'd1 || corr_rsn == 2'd2)); // R9

  AST_NO_EVT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(frozen) |-> !corr_evt); // R11

endmodule

bind soc_integrator soc_integrator_chk #(
  .SOC_W      (SOC_W),
  .STEP_MAX   (STEP_MAX),
  .TICK_CYCLES(TICK_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp_vld (smp_vld),
  .pstate  (pstate),
  .soc     (soc),
  .corr_evt(corr_evt),
  .corr_rsn(corr_rsn)
);

// File: tb/soc_integrator_bench.sv
module soc_integrator_bench;

  localparam int CUR_W  = 12;
  localparam int GAIN_W = 10;
  localparam int FRAC_W = 8;
  localparam int STEPM  = 300;
  localparam int TICK   = 8;
  localparam int OFF_SH = 2;
  localparam int TS_W   = 16;
  localparam int SOC_W  = 14;
  localparam longint FULL = 64'sd10000 <<< FRAC_W;

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    smp_vld;
  logic signed [CUR_W-1:0] smp_ma;
  logic                    chg_pos;
  logic [GAIN_W-1:0]       gain;
  logic [1:0]              pstate;
  logic [SOC_W-1:0]        ocv_soc;
  logic [SOC_W-1:0]        soc;
  logic                    corr_evt;
  logic [1:0]              corr_rsn;
  logic [TS_W-1:0]         corr_ts;

  int     checks = 0;
  int     errors = 0;
  bit     done   = 0;
  longint m_acc  = 0;
  int     m_off  = 0;

  always #4 clk = ~clk;

  soc_integrator #(
    .CUR_W(CUR_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .STEP_MAX(STEPM),
    .TICK_CYCLES(TICK), .OFF_SH(OFF_SH), .TS_W(TS_W)
  ) u_soc_integrator (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_ma(smp_ma),
    .chg_pos(chg_pos), .gain(gain), .pstate(pstate), .ocv_soc(ocv_soc),
    .soc(soc), .corr_evt(corr_evt), .corr_rsn(corr_rsn), .corr_ts(corr_ts)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic longint m_soc();
    return m_acc >>> FRAC_W;
  endfunction

  task automatic do_sample(input int cur, input string req);
    int adj;
    smp_ma  = CUR_W'(cur);
    smp_vld = 1'b1;
    tick();
    smp_vld = 1'b0;
    if (pstate == 2'd1 || pstate == 2'd2) begin
      m_off = m_off + ((cur - m_off) >>> OFF_SH);
    end else begin
      adj = cur - m_off;
      if (!chg_pos) adj = -adj;
      m_acc = m_acc + longint'(adj) * longint'(gain);
      if (m_acc < 0) m_acc = 0;
      if (m_acc > FULL) m_acc = FULL;
    end
    chk(req, longint'(soc), m_soc());
  endtask

  // Leave a resting state and follow the bounded re-anchoring cycle by cycle.
  task automatic do_exit(input logic [1:0] nst, input int target, input int exp_rsn,
                         input int ncyc);
    bit     reached = 0;
    bit     have_ts = 0;
    int     last_ts = 0;
    longint d;
    bit     exp_evt;
    pstate  = nst;
    ocv_soc = SOC_W'(target);
    tick();
    chk("R7 no event on exit edge", longint'(corr_evt), 0);
    for (int c = 1; c <= ncyc; c++) begin
      tick();
      exp_evt = 1'b0;
      if ((c % TICK) == 0 && !reached) begin
        d = longint'(target) - m_soc();
        if (d == 0) begin
          reached = 1;
        end else begin
          if (d > STEPM) d = STEPM;
          if (d < -STEPM) d = -STEPM;
          m_acc = m_acc + (d <<< FRAC_W);
          exp_evt = 1'b1;
          if (m_soc() == longint'(target)) reached = 1;
        end
      end
      chk("R7 event timing", longint'(corr_evt), longint'(exp_evt));
      chk("R8 bounded step soc", longint'(soc), m_soc());
      if (exp_evt) begin
        chk("R9 reason code", longint'(corr_rsn), longint'(exp_rsn));
        if (have_ts) chk("R9 timestamp spacing", longint'(TS_W'(corr_ts - TS_W'(last_ts))), TICK);
        last_ts = int'(corr_ts);
        have_ts = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; smp_vld = 1'b0; smp_ma = '0; chg_pos = 1'b1;
    gain = GAIN_W'(256); pstate = 2'd0; ocv_soc = '0;
    repeat (4) tick();
    chk("R1 soc in reset", longint'(soc), 0);
    rst = 1'b0;
    tick();
    chk("R1 soc after reset", longint'(soc), 0);
    chk("R1 evt after reset", longint'(corr_evt), 0);
    chk("R1 rsn after reset", longint'(corr_rsn), 0);

    // R7 R8 R9: hold -> run re-anchors toward 50.00 % in 3 % steps.
    pstate = 2'd1;
    tick();
    do_exit(2'd0, 5000, 2, 19 * TICK);

    // R2 R3: sweep gains, polarities and currents in run.
    for (int gi = 0; gi < 3; gi++) begin
      gain = (gi == 0) ? GAIN_W'(256) : (gi == 1) ? GAIN_W'(64) : GAIN_W'(100);
      for (int p = 0; p < 2; p++) begin
        chg_pos = p[0];
        for (int cur = -30; cur <= 30; cur += 7) begin
          do_sample(cur, "R2 integrate sweep");
        end
      end
    end

    // R4: fractional residue.
    chg_pos = 1'b1;
    gain = GAIN_W'(64);
    for (int k = 0; k < 8; k++) do_sample(1, "R4 residue");

    // R3: positive sample as discharge.
    chg_pos = 1'b0;
    gain = GAIN_W'(256);
    do_sample(100, "R3 polarity discharge");
    chg_pos = 1'b1;
    do_sample(100, "R3 polarity charge");

    // R5: saturation at both ends.
    gain = GAIN_W'(1023);
    for (int k = 0; k < 3; k++) do_sample(2000, "R5 saturate full");
    chk("R5 soc full", longint'(soc), 10000);
    for (int k = 0; k < 3; k++) do_sample(-2000, "R5 saturate empty");
    chk("R5 soc empty", longint'(soc), 0);

    // R6 R10: frozen strobes leave soc, teach offset.
    gain = GAIN_W'(256);
    pstate = 2'd1;
    tick();
    for (int k = 0; k < 6; k++) do_sample(40, "R6 hold frozen");
    pstate = 2'd2;
    tick();
    for (int k = 0; k < 2; k++) do_sample(-20, "R6 ship frozen");

    // R9: ship -> wake reason code.
    do_exit(2'd3, 2000, 1, 8 * TICK);

    // R10: offset removal during wake.
    do_sample(m_off, "R10 offset cancels");
    do_sample(m_off + 50, "R10 offset subtracted");

    // R11: abort a downward re-anchoring by re-entering hold.
    pstate = 2'd1;
    tick();
    do_exit(2'd0, 100, 2, TICK);
    pstate = 2'd1;
    for (int c = 0; c < 3 * TICK; c++) begin
      tick();
      chk("R11 no event after abort", longint'(corr_evt), 0);
      chk("R11 soc held after abort", longint'(soc), m_soc());
    end

    // R8: exit with soc already at target gives no event.
    do_exit(2'd0, int'(m_soc()), 2, 2 * TICK);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule